// File: doc/BRIEF.md
# Bit-Field Descriptor Load/Store Unit

This unit moves a bit field of 0 to 24 bits between a 24-bit accumulator and a word-addressed memory. A 24-bit descriptor locates the field by word address, starting bit offset and length. A field may start near the end of one word and continue into the next word. When it does, the unit reads both words, and for a store it writes both back. The length or the offset can be taken from an index register by putting a sentinel value in the descriptor. The indexed operations add the index register's address field to the descriptor address.

The advance operations serve loops that walk a packed string of fields. Each one first compares the descriptor's position with a limit descriptor. If the positions differ, it performs the access, moves the descriptor forward by the field length and raises a skip flag. A caller pulses `start_i` with all operands on the input ports. The caller then waits for the one-cycle `done_o` pulse and reads the accumulator, the descriptor, the skip flag and the fault flag. Memory traffic uses a request/acknowledge handshake. A read returns its data in the acknowledge cycle.

Top module: `fd_unit`

## Requirements
- R1: The descriptor fields are: length in `[23:19]`, offset in `[18:14]` and word address in `[13:0]`. Offset 0 names the most significant bit (vector bit 23) of the word. A load returns the field right-aligned in `acc_o` with every higher bit cleared. `desc_o` equals `desc_i`, and neither skip nor fault is raised.
- R2: A store replaces the field in memory with the low `length` bits of `acc_i`. Every other memory bit is left unchanged, and `acc_o` equals `acc_i`.
- R3: A field whose offset plus length exceeds 24 continues from the low bits of the word at `addr` into the high bits of the word at `addr+1`. Such a field costs two reads, plus two writes for a store. A field that fits in one word costs one read, plus one write for a store.
- R4: A length field of 31 is replaced by `index_i[23:19]`. An offset field of 31 is replaced by `index_i[18:14]`.
- R5: The unit raises `fault_o` when the resolved offset exceeds 23 or the resolved length exceeds 24. A faulting operation makes no memory request, returns `acc_o = acc_i` and `desc_o = desc_i`, and leaves `skip_o` at 0.
- R6: The indexed operations use the effective address `(desc address + index_i[13:0]) mod 2^14`. For these operations `desc_o` equals `desc_i`.
- R7: An advance operation first compares its resolved offset and address with the offset and address fields of `limit_i`. If both are equal, it makes no memory request, returns `skip_o = 0`, `acc_o = acc_i` and `desc_o = desc_i`.
- R8: Otherwise an advance operation performs the access and then adds the length to the offset. A sum above 23 becomes sum − 24 and increments the address modulo 2^14. `desc_o` carries the original length field with the new offset and address, and `skip_o` is 1.
- R9: A zero-length field makes no memory request. A load of such a field returns 0, and a store of it changes nothing.
- R10: `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` hold steady until `mem_ack_i`. `done_o` is a one-cycle pulse. `start_i` is ignored while `busy_o` is high, and there is no request while the unit is idle.
- R11: The `op_i` encoding is: 0 load, 1 store, 2 indexed load, 3 indexed store, 4 advance load, 5 advance store. The values 6 and 7 raise `fault_o` in the same way as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| op_i | input | 3 | Operation code (R11) |
| desc_i | input | 24 | Field descriptor |
| limit_i | input | 24 | Limit descriptor for the advance operations |
| index_i | input | 24 | Index register |
| acc_i | input | 24 | Accumulator input |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 14 | Memory word address |
| mem_wdata_o | output | 24 | Write data |
| mem_rdata_i | input | 24 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | 24 | Resulting accumulator |
| desc_o | output | 24 | Resulting descriptor |
| skip_o | output | 1 | Advance performed |
| fault_o | output | 1 | Descriptor or op code rejected |

## Verification
A wrong shift amount or a wrong mask shows up in the accumulator or in the memory words at the first `done_o` after the faulty operation. A stale word latch shows up only on fields that cross a word boundary. A wrong straddle decision shows up earlier than that, as a missing or extra read or write on the memory port during the operation itself. A broken offset wrap or address carry in the advance path appears in `desc_o` at the same `done_o`, but only when the offset plus the length reaches 24. For that reason the exact-fit and overflow cases are exercised separately.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int WORD_W   = 24;
  localparam int LEN_W    = 5;
  localparam int OFF_W    = 5;
  localparam int ADDR_W   = 14;
  localparam int SENTINEL = (1 << LEN_W) - 1;
  localparam int CAT_W    = 2 * WORD_W;
  localparam int SH_W     = $clog2(CAT_W + 1);

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [OFF_W-1:0]  off;
    logic [ADDR_W-1:0] addr;
  } fd_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RD0, ST_RD1, ST_WR0, ST_WR1, ST_FIN, ST_DONE
  } fd_state_e;

  // Right-aligned mask of len ones.
  function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    if (int'(len) >= WORD_W) return '1;
    return (WORD_W'(1) << len) - WORD_W'(1);
  endfunction

  // Bits between the field's last bit and the end of the two-word window.
  function automatic logic [SH_W-1:0] right_gap(input logic [OFF_W-1:0] off,
                                                input logic [LEN_W-1:0] len);
    return SH_W'(CAT_W - int'(off) - int'(len));
  endfunction
endpackage

// File: rtl/fd_resolve.sv
module fd_resolve
  import fd_pkg::*;
(
  input  logic [WORD_W-1:0] desc_i,
  input  logic [WORD_W-1:0] index_i,
  input  logic [2:0]        op_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic              is_store_o,
  output logic              is_adv_o,
  output logic              fault_o,
  output logic              straddle_o,
  output logic              len_zero_o
);
  fd_desc_t d, x;
  logic [1:0] mode;
  logic       is_idx, bad_op;
  logic [OFF_W:0] span;

  assign d = fd_desc_t'(desc_i);
  assign x = fd_desc_t'(index_i);

  always_comb begin
    mode       = op_i[2:1];
    is_store_o = op_i[0];
    is_idx     = (mode == 2'b01);
    is_adv_o   = (mode == 2'b10);
    bad_op     = (mode == 2'b11);
    len_o      = (d.len == LEN_W'(SENTINEL)) ? x.len : d.len;
    off_o      = (d.off == OFF_W'(SENTINEL)) ? x.off : d.off;
    ea_o       = d.addr + (is_idx ? x.addr : '0);
    fault_o    = bad_op || (off_o > OFF_W'(WORD_W - 1)) || (len_o > LEN_W'(WORD_W));
    span       = {1'b0, off_o} + {1'b0, len_o};
    straddle_o = (span > (OFF_W+1)'(WORD_W));
    len_zero_o = (len_o == '0);
  end
endmodule

// File: rtl/fd_merge.sv
module fd_merge
  import fd_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] w1_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [WORD_W-1:0] field_o,
  output logic [WORD_W-1:0] nw0_o,
  output logic [WORD_W-1:0] nw1_o
);
  logic [SH_W-1:0]   sh;
  logic [WORD_W-1:0] m;
  logic [CAT_W-1:0]  cat, fmask, placed, merged;

  always_comb begin
    sh      = right_gap(off_i, len_i);
    m       = len_mask(len_i);
    cat     = {w0_i, w1_i};
    fmask   = {{WORD_W{1'b0}}, m} << sh;
    placed  = {{WORD_W{1'b0}}, acc_i & m} << sh;
    merged  = (cat & ~fmask) | placed;
    field_o = WORD_W'(cat >> sh) & m;
  end

  assign nw0_o = merged[CAT_W-1:WORD_W];
  assign nw1_o = merged[WORD_W-1:0];
endmodule

// File: rtl/fd_step.sv
module fd_step
  import fd_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] limit_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  noff_o,
  output logic [ADDR_W-1:0] naddr_o
);
  fd_desc_t lim;
  logic [OFF_W:0] sum;
  logic           wrap;

  assign lim = fd_desc_t'(limit_i);

  always_comb begin
    hit_o   = (off_i == lim.off) && (addr_i == lim.addr);
    sum     = {1'b0, off_i} + (OFF_W+1)'(len_i);
    wrap    = (sum > (OFF_W+1)'(WORD_W - 1));
    noff_o  = wrap ? OFF_W'(sum - (OFF_W+1)'(WORD_W)) : sum[OFF_W-1:0];
    naddr_o = addr_i + ADDR_W'(wrap);
  end
endmodule

// File: rtl/fd_unit.sv
module fd_unit
  import fd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [WORD_W-1:0] desc_i,
  input  logic [WORD_W-1:0] limit_i,
  input  logic [WORD_W-1:0] index_i,
  input  logic [WORD_W-1:0] acc_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [WORD_W-1:0] desc_o,
  output logic              skip_o,
  output logic              fault_o
);
  fd_state_e         state;
  logic [2:0]        op_q;
  logic [WORD_W-1:0] desc_q, limit_q, index_q, acc_q, w0_q, w1_q;

  logic [LEN_W-1:0]  len_w;
  logic [OFF_W-1:0]  off_w, noff_w;
  logic [ADDR_W-1:0] ea_w, naddr_w;
  logic [WORD_W-1:0] field_w, nw0_w, nw1_w;
  logic              is_store_w, is_adv_w, fault_w, straddle_w, len_zero_w;
  logic              hit_w, limit_hit_w, proceed_w;
  fd_desc_t          dq, adv_desc;

  fd_resolve u_resolve (
    .desc_i(desc_q), .index_i(index_q), .op_i(op_q),
    .len_o(len_w), .off_o(off_w), .ea_o(ea_w),
    .is_store_o(is_store_w), .is_adv_o(is_adv_w), .fault_o(fault_w),
    .straddle_o(straddle_w), .len_zero_o(len_zero_w)
  );

  fd_step u_step (
    .off_i(off_w), .len_i(len_w), .addr_i(ea_w), .limit_i(limit_q),
    .hit_o(hit_w), .noff_o(noff_w), .naddr_o(naddr_w)
  );

  fd_merge u_merge (
    .w0_i(w0_q), .w1_i(w1_q), .acc_i(acc_q), .len_i(len_w), .off_i(off_w),
    .field_o(field_w), .nw0_o(nw0_w), .nw1_o(nw1_w)
  );

  // Named events used by the checker.
  assign limit_hit_w = is_adv_w && hit_w;
  assign proceed_w   = !fault_w && !limit_hit_w;
  assign dq          = fd_desc_t'(desc_q);

  always_comb begin
    adv_desc      = dq;
    adv_desc.off  = noff_w;
    adv_desc.addr = naddr_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= '0;
      desc_q  <= '0;
      limit_q <= '0;
      index_q <= '0;
      acc_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      acc_o   <= '0;
      desc_o  <= '0;
      skip_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          op_q    <= op_i;
          desc_q  <= desc_i;
          limit_q <= limit_i;
          index_q <= index_i;
          acc_q   <= acc_i;
          state   <= ST_CHECK;
        end
        ST_CHECK: state <= (!proceed_w || len_zero_w) ? ST_FIN : ST_RD0;
        ST_RD0: if (mem_ack_i) begin
          w0_q  <= mem_rdata_i;
          state <= straddle_w ? ST_RD1 : (is_store_w ? ST_WR0 : ST_FIN);
        end
        ST_RD1: if (mem_ack_i) begin
          w1_q  <= mem_rdata_i;
          state <= is_store_w ? ST_WR0 : ST_FIN;
        end
        ST_WR0: if (mem_ack_i) state <= straddle_w ? ST_WR1 : ST_FIN;
        ST_WR1: if (mem_ack_i) state <= ST_FIN;
        ST_FIN: begin
          fault_o <= fault_w;
          skip_o  <= proceed_w && is_adv_w;
          if (proceed_w && !is_store_w) acc_o <= len_zero_w ? '0 : field_w;
          else                          acc_o <= acc_q;
          desc_o  <= (proceed_w && is_adv_w) ? WORD_W'(adv_desc) : desc_q;
          state   <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ea_w;
    mem_wdata_o = nw0_w;
    unique case (state)
      ST_RD0: mem_req_o = 1'b1;
      ST_RD1: begin mem_req_o = 1'b1; mem_addr_o = ea_w + ADDR_W'(1); end
      ST_WR0: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      ST_WR1: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ea_w + ADDR_W'(1);
        mem_wdata_o = nw1_w;
      end
      default: ;
    endcase
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);
endmodule

// File: rtl/fd_unit_chk.sv
module fd_unit_chk
  import fd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              skip_o,
  input logic              fault_o,
  input logic              fault_w,
  input logic              limit_hit_w,
  input logic              len_zero_w,
  input logic              is_store_w,
  input logic              is_adv_w
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  assert_fault_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !fault_w);

  assert_fault_no_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_o |-> !skip_o);

  assert_limit_no_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !limit_hit_w);

  assert_zero_no_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !len_zero_w);

  assert_write_only_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> is_store_w);

  assert_skip_only_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && skip_o |-> is_adv_w);
endmodule

bind fd_unit fd_unit_chk chk_i (.*);

// File: tb/fd_unit_tb_top.sv
`timescale 1ns/1ps
module fd_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [23:0] desc_i = '0, limit_i = '0, index_i = '0, acc_i = '0;
  logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [13:0] mem_addr_o;
  logic [23:0] mem_wdata_o, mem_rdata_i = '0;
  logic        busy_o, done_o, skip_o, fault_o;
  logic [23:0] acc_o, desc_o;

  logic [23:0] mem [0:16383];
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  int n_chk = 0, n_fail = 0;
  int d_rd, d_wr, d_done;

  always #2.5 clk = ~clk;

  fd_unit dut_i (.*);

  // Memory model: acknowledges one cycle after a new request.
  always @(posedge clk) begin
    if (!rst_n) mem_ack_i <= 1'b0;
    else if (mem_req_o && !mem_ack_i) begin
      mem_ack_i   <= 1'b1;
      mem_rdata_i <= mem[mem_addr_o];
      if (mem_we_o) begin mem[mem_addr_o] <= mem_wdata_o; wr_cnt <= wr_cnt + 1; end
      else rd_cnt <= rd_cnt + 1;
    end else mem_ack_i <= 1'b0;
    if (done_o) done_cnt <= done_cnt + 1;
  end

  function automatic logic [23:0] mkd(input int len, input int off, input int addr);
    return {5'(len), 5'(off), 14'(addr)};
  endfunction

  // Reference: walk the field bit by bit from its left end.
  function automatic logic [23:0] ref_get(input logic [23:0] a, input logic [23:0] b,
                                          input int off, input int len);
    logic [23:0] v = '0;
    for (int i = 0; i < len; i++) begin
      int p = off + i;
      v = {v[22:0], (p < 24) ? a[23-p] : b[47-p]};
    end
    return v;
  endfunction

  function automatic logic [47:0] ref_put(input logic [23:0] a, input logic [23:0] b,
                                          input logic [23:0] v, input int off, input int len);
    logic [47:0] w = {a, b};
    for (int i = 0; i < len; i++) w[47-(off+i)] = v[len-1-i];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [23:0] d, input logic [23:0] lim,
                        input logic [23:0] ix, input logic [23:0] acc, input bit poke_busy);
    int r0 = rd_cnt, w0 = wr_cnt, dn0 = done_cnt;
    @(negedge clk);
    op_i = op; desc_i = d; limit_i = lim; index_i = ix; acc_i = acc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_busy) begin
      op_i = 3'd1; desc_i = mkd(24, 0, 0); acc_i = 24'h0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    if (poke_busy) repeat (6) @(negedge clk);
    d_rd = rd_cnt - r0; d_wr = wr_cnt - w0; d_done = done_cnt - dn0;
  endtask

  task automatic t_reset();
    chk("R10 reset busy", 48'(busy_o), 0);
    chk("R10 reset done", 48'(done_o), 0);
    chk("R10 reset req", 48'(mem_req_o), 0);
    chk("R5 reset fault", 48'(fault_o), 0);
    chk("R8 reset skip", 48'(skip_o), 0);
  endtask

  task automatic t_load_simple();
    logic [23:0] d = mkd(8, 4, 100);
    run_op(3'd0, d, 0, 0, 24'h5A5A5A, 0);
    chk("R1 load value", 48'(acc_o), 48'(ref_get(mem[100], mem[101], 4, 8)));
    chk("R1 desc echo", 48'(desc_o), 48'(d));
    chk("R1 no skip/fault", {46'd0, skip_o, fault_o}, 0);
    chk("R3 single read", 48'(d_rd), 1);
    run_op(3'd0, mkd(24, 0, 101), 0, 0, 0, 0);
    chk("R1 full word", 48'(acc_o), 48'(mem[101]));
    run_op(3'd0, mkd(5, 19, 102), 0, 0, 24'hFFFFFF, 0);
    chk("R1 right edge", 48'(acc_o), 48'(mem[102][4:0]));
  endtask

  task automatic t_load_straddle();
    run_op(3'd0, mkd(10, 20, 200), 0, 0, 0, 0);
    chk("R3 straddle load", 48'(acc_o), 48'(ref_get(mem[200], mem[201], 20, 10)));
    chk("R3 two reads", 48'(d_rd), 2);
  endtask

  task automatic t_store();
    logic [47:0] e = ref_put(mem[300], mem[301], 24'hFFF0AB, 6, 7);
    logic [23:0] keep = mem[301];
    run_op(3'd1, mkd(7, 6, 300), 0, 0, 24'hFFF0AB, 0);
    chk("R2 store word", 48'(mem[300]), 48'(e[47:24]));
    chk("R2 neighbour kept", 48'(mem[301]), 48'(keep));
    chk("R2 acc kept", 48'(acc_o), 48'h0000_00FF_F0AB);
    chk("R3 one write", 48'(d_wr), 1);
  endtask

  task automatic t_store_straddle();
    logic [47:0] e = ref_put(mem[400], mem[401], 24'h12345, 17, 15);
    logic [23:0] keep = mem[402];
    run_op(3'd1, mkd(15, 17, 400), 0, 0, 24'h12345, 0);
    chk("R3 straddle words", {mem[400], mem[401]}, e);
    chk("R3 next word kept", 48'(mem[402]), 48'(keep));
    chk("R3 two writes", 48'(d_wr), 2);
  endtask

  task automatic t_sentinel();
    run_op(3'd0, mkd(31, 31, 500), 0, mkd(6, 9, 77), 0, 0);
    chk("R4 indirect len/off", 48'(acc_o), 48'(ref_get(mem[500], mem[501], 9, 6)));
    run_op(3'd0, mkd(31, 2, 501), 0, mkd(12, 30, 0), 0, 0);
    chk("R4 indirect len only", 48'(acc_o), 48'(ref_get(mem[501], mem[502], 2, 12)));
  endtask

  task automatic t_fault();
    logic [23:0] d = mkd(1, 24, 10);
    run_op(3'd4, d, mkd(0, 0, 0), 0, 24'h00C0DE, 0);
    chk("R5 offset fault", 48'(fault_o), 1);
    chk("R5 no access", 48'(d_rd + d_wr), 0);
    chk("R5 acc kept", 48'(acc_o), 48'h00C0DE);
    chk("R5 desc kept", 48'(desc_o), 48'(d));
    chk("R5 no skip", 48'(skip_o), 0);
    run_op(3'd0, mkd(25, 0, 10), 0, 0, 0, 0);
    chk("R5 length fault", 48'(fault_o), 1);
    run_op(3'd1, mkd(2, 31, 10), 0, mkd(0, 30, 0), 0, 0);
    chk("R5 indirect offset fault", {47'd0, fault_o}, 1);
    chk("R5 indirect no write", 48'(d_wr), 0);
    run_op(3'd0, mkd(24, 0, 10), 0, 0, 0, 0);
    chk("R5 max length ok", 48'(fault_o), 0);
  endtask

  task automatic t_reserved();
    run_op(3'd6, mkd(4, 0, 20), 0, 0, 24'h1, 0);
    chk("R11 op 6 faults", 48'(fault_o), 1);
    run_op(3'd7, mkd(4, 0, 20), 0, 0, 24'h1, 0);
    chk("R11 op 7 faults", 48'(fault_o), 1);
    chk("R11 op 7 no access", 48'(d_rd + d_wr), 0);
  endtask

  task automatic t_indexed();
    logic [23:0] d = mkd(12, 3, 16380);
    logic [47:0] e;
    run_op(3'd2, d, 0, mkd(0, 0, 10), 0, 0);
    chk("R6 indexed load wraps", 48'(acc_o), 48'(ref_get(mem[6], mem[7], 3, 12)));
    chk("R6 desc echo", 48'(desc_o), 48'(d));
    e = ref_put(mem[604], mem[605], 24'hABC, 10, 12);
    run_op(3'd3, mkd(12, 10, 600), 0, mkd(0, 0, 4), 24'hABC, 0);
    chk("R6 indexed store", 48'(mem[604]), 48'(e[47:24]));
  endtask

  task automatic t_advance();
    logic [47:0] e;
    run_op(3'd4, mkd(8, 20, 700), mkd(0, 0, 0), 0, 0, 0);
    chk("R8 adv load value", 48'(acc_o), 48'(ref_get(mem[700], mem[701], 20, 8)));
    chk("R8 adv wrap desc", 48'(desc_o), 48'(mkd(8, (700*24+28)%24, (700*24+28)/24)));
    chk("R8 adv skip", 48'(skip_o), 1);
    e = ref_put(mem[800], mem[801], 24'h15, 2, 5);
    run_op(3'd5, mkd(5, 2, 800), mkd(5, 2, 801), 0, 24'h15, 0);
    chk("R8 adv store mem", 48'(mem[800]), 48'(e[47:24]));
    chk("R8 adv step desc", 48'(desc_o), 48'(mkd(5, 7, 800)));
    run_op(3'd4, mkd(8, 16, 16383), 0, 0, 0, 0);
    chk("R8 exact fit wraps", 48'(desc_o), 48'(mkd(8, 0, 0)));
  endtask

  task automatic t_limit();
    logic [23:0] d = mkd(8, 4, 900);
    run_op(3'd4, d, mkd(3, 4, 900), 0, 24'h777, 0);
    chk("R7 limit no skip", 48'(skip_o), 0);
    chk("R7 limit no access", 48'(d_rd), 0);
    chk("R7 limit acc kept", 48'(acc_o), 48'h777);
    chk("R7 limit desc kept", 48'(desc_o), 48'(d));
    run_op(3'd4, d, mkd(8, 5, 900), 0, 0, 0);
    chk("R7 offset mismatch proceeds", 48'(skip_o), 1);
  endtask

  task automatic t_zero();
    logic [23:0] keep = mem[950];
    run_op(3'd0, mkd(0, 5, 950), 0, 0, 24'hFFFFFF, 0);
    chk("R9 zero load", 48'(acc_o), 0);
    chk("R9 zero load no read", 48'(d_rd), 0);
    run_op(3'd1, mkd(0, 23, 950), 0, 0, 24'hFFFFFF, 0);
    chk("R9 zero store no write", 48'(d_wr), 0);
    chk("R9 zero store mem", 48'(mem[950]), 48'(keep));
    chk("R9 zero store acc", 48'(acc_o), 48'hFFFFFF);
  endtask

  task automatic t_busy();
    logic [23:0] keep = mem[0];
    run_op(3'd0, mkd(10, 20, 1000), 0, 0, 0, 1);
    chk("R10 one done", 48'(d_done), 1);
    chk("R10 first op result", 48'(acc_o), 48'(ref_get(mem[1000], mem[1001], 20, 10)));
    chk("R10 second start dropped", 48'(mem[0]), 48'(keep));
    chk("R10 idle after", 48'(busy_o), 0);
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = 24'((i * 40503 + 12345) ^ (i << 11));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_simple();
    t_load_straddle();
    t_store();
    t_store_straddle();
    t_sentinel();
    t_fault();
    t_reserved();
    t_indexed();
    t_advance();
    t_limit();
    t_zero();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule